// File: doc/BRIEF.md
# Reset and Wake-Up Sequencer

This block decides when a small controller core may run. It sorts every reset into one of three kinds: a cold reset from the power-on detector, a full reset from the external reset pin or a watchdog overflow, and a warm reset. The warm reset touches only the program counter and stack pointer and is raised when the watchdog expires while the core is halted. Each reset's cause is recorded in two sticky status flags: a time-out flag (TO) and a power-down flag (PDF).

The block also handles the halt state. A halt strobe parks the core. It wakes on the reset pin, a watchdog overflow, a falling edge on any selected port bit, or a newly raised enabled interrupt request. A start-up counter holds the core stopped for a fixed number of clocks after power-up and after every wake-up from halt. A pin reset skips that wait. After an interrupt wake, the block grants a one-cycle interrupt-take slot when interrupts are globally enabled and the stack has room. Otherwise the core simply resumes.

Top module: `rstwake_ctrl`

## Requirements
- R1: While `por` is high, `full_rst` is 1, `run_en` is 0 and both flags read 0. After `por` falls, `run_en` rises on the SETTLE_CYC-th (default 1024) rising edge, and `full_rst` stays high until then.
- R2: A pin reset while running holds `full_rst` high and `run_en` low for as long as the pin is held, and leaves both flags unchanged. `run_en` returns one clock after the pin is released, with no start-up wait.
- R3: A pin reset while halted (including during a wake-up wait) gives TO=0 and PDF=1, clears `halted` and asserts `full_rst`. The core runs one clock after release, with no start-up wait.
- R4: A watchdog overflow while running gives a one-cycle `full_rst`, sets TO, leaves PDF unchanged, and lets the core run on the next clock.
- R5: A halt strobe while running raises `halted`, drops `run_en`, sets PDF and clears TO.
- R6: A clear-watchdog strobe while running clears PDF and leaves TO unchanged.
- R7: A watchdog overflow while halted gives a one-cycle `warm_rst` with `full_rst` low, and sets TO=1 and PDF=1. `run_en` rises SETTLE_CYC+2 edges after the overflow is sampled.
- R8: While halted, a high-to-low change on a port bit whose `pa_wake_mask` bit is 1 wakes the core, and `run_en` rises SETTLE_CYC+1 edges later. Falling edges on unmasked bits and rising edges on any bit leave the core halted. A port wake leaves the flags unchanged.
- R9: A request bit that is already high when halt is entered, or whose `irq_en` bit is 0, does not wake the core. A request bit that is enabled and was low at halt entry does wake it.
- R10: After an interrupt wake with `glb_ie`=1 and `stack_full`=0, `int_take` is 1 for exactly one cycle on edge SETTLE_CYC+1 with `run_en` low, and `run_en` rises on the next edge. If `glb_ie`=0 or `stack_full`=1, `run_en` rises on edge SETTLE_CYC+1 and `int_take` never pulses.
- R11: `halted` stays high through the start-up wait after a wake-up. It falls on the same edge at which `run_en` or `int_take` rises, and `halted` and `run_en` are never high together.
- R12: `full_rst` and `warm_rst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on detect, synchronous active-high cold reset |
| rst_pin | input | 1 | External reset pin (synchronized, active high) |
| halt_cmd | input | 1 | One-cycle halt instruction strobe |
| clr_wdt | input | 1 | One-cycle clear-watchdog instruction strobe |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| pa_in | input | PA_W | Port pins watched for wake-up edges |
| pa_wake_mask | input | PA_W | Per-bit wake select (1 = bit may wake) |
| irq_req | input | NIRQ | Interrupt request flags |
| irq_en | input | NIRQ | Per-source interrupt enables |
| glb_ie | input | 1 | Global interrupt enable |
| stack_full | input | 1 | Call stack has no free slot |
| flag_to | output | 1 | Time-out status flag |
| flag_pdf | output | 1 | Power-down status flag |
| full_rst | output | 1 | Full reset to the core |
| warm_rst | output | 1 | Reset of program counter and stack pointer only |
| run_en | output | 1 | Core may execute |
| int_take | output | 1 | One-cycle interrupt response slot |
| halted | output | 1 | Core is halted or waiting to resume |

## Verification
The bench measures the exact length of every start-up wait. A counter that is off by one, or that is wrongly applied to or skipped on a pin reset, shows up as a wrong cycle count. It walks the wake mask over every port bit and drives unmasked falls and masked rises first. A design that watched the wrong edge or ignored the mask would wake too early or not at all. For interrupts it raises a request before halt and another on a disabled source, which must not wake the core. It then checks that the take slot appears only with the global enable set and the stack not full. Flag values are compared after every reset kind, so a confused cause encoding, such as a warm reset that also clears the flags or a pin reset that disturbs them, is reported.

// File: rtl/rstwake_pkg.sv
package rstwake_pkg;

  typedef enum logic [2:0] {
    ST_COLD,   // power-up start-up wait
    ST_RUN,    // normal execution
    ST_PIN,    // reset pin held
    ST_WDR,    // watchdog full reset, one cycle
    ST_HALT,   // parked
    ST_WARM,   // warm reset pulse, one cycle
    ST_WAKE,   // start-up wait after wake-up
    ST_TAKE    // interrupt response slot
  } rw_state_e;

  function automatic logic is_parked(rw_state_e s);
    return (s == ST_HALT) || (s == ST_WARM) || (s == ST_WAKE);
  endfunction

  function automatic logic is_full_rst(rw_state_e s);
    return (s == ST_COLD) || (s == ST_PIN) || (s == ST_WDR);
  endfunction

endpackage

// File: rtl/rw_settle.sv
module rw_settle #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST_V = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (en && !last)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rw_wake_src.sv
module rw_wake_src #(
  parameter int PA_W = 8,
  parameter int NIRQ = 2
) (
  input  logic            clk,
  input  logic            por,
  input  logic            arm,
  input  logic [PA_W-1:0] pa_in,
  input  logic [PA_W-1:0] pa_mask,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            pa_hit,
  output logic            irq_hit
);
  logic [PA_W-1:0] pa_q;
  logic [NIRQ-1:0] pend_q;   // requests already raised when halt began

  always_ff @(posedge clk) begin
    pa_q <= pa_in;
  end

  always_ff @(posedge clk) begin
    if (por)
      pend_q <= '0;
    else if (arm)
      pend_q <= irq_req;
  end

  assign pa_hit  = |(pa_q & ~pa_in & pa_mask);
  assign irq_hit = |(irq_req & irq_en & ~pend_q);
endmodule

// File: rtl/rstwake_ctrl.sv
module rstwake_ctrl
  import rstwake_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int PA_W       = 8,
  parameter int NIRQ       = 2
) (
  input  logic            clk,
  input  logic            por,
  input  logic            rst_pin,
  input  logic            halt_cmd,
  input  logic            clr_wdt,
  input  logic            wdt_ovf,
  input  logic [PA_W-1:0] pa_in,
  input  logic [PA_W-1:0] pa_wake_mask,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  input  logic            glb_ie,
  input  logic            stack_full,
  output logic            flag_to,
  output logic            flag_pdf,
  output logic            full_rst,
  output logic            warm_rst,
  output logic            run_en,
  output logic            int_take,
  output logic            halted
);
  rw_state_e st, st_n, st_d;
  logic to_n, pdf_n;
  logic irqw_q, irqw_n;
  logic st_last, st_clr, st_en;
  logic pa_hit, irq_hit, arm;

  rw_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk  (clk),
    .clr  (st_clr),
    .en   (st_en),
    .last (st_last)
  );

  rw_wake_src #(.PA_W(PA_W), .NIRQ(NIRQ)) u_wake (
    .clk     (clk),
    .por     (por),
    .arm     (arm),
    .pa_in   (pa_in),
    .pa_mask (pa_wake_mask),
    .irq_req (irq_req),
    .irq_en  (irq_en),
    .pa_hit  (pa_hit),
    .irq_hit (irq_hit)
  );

  always_comb begin
    st_n   = st;
    to_n   = flag_to;
    pdf_n  = flag_pdf;
    irqw_n = irqw_q;
    case (st)
      ST_COLD: if (st_last) st_n = ST_RUN;
      ST_RUN: begin
        if (rst_pin) begin
          st_n = ST_PIN;
        end else if (wdt_ovf) begin
          st_n = ST_WDR;
          to_n = 1'b1;
        end else if (halt_cmd) begin
          st_n  = ST_HALT;
          pdf_n = 1'b1;
          to_n  = 1'b0;
        end else if (clr_wdt) begin
          pdf_n = 1'b0;
        end
      end
      ST_PIN:  if (!rst_pin) st_n = ST_RUN;
      ST_WDR:  st_n = ST_RUN;
      ST_HALT, ST_WARM, ST_WAKE: begin
        if (rst_pin) begin
          st_n  = ST_PIN;
          to_n  = 1'b0;
          pdf_n = 1'b1;
        end else if (st == ST_HALT) begin
          if (wdt_ovf) begin
            st_n   = ST_WARM;
            to_n   = 1'b1;
            pdf_n  = 1'b1;
            irqw_n = 1'b0;
          end else if (pa_hit || irq_hit) begin
            st_n   = ST_WAKE;
            irqw_n = irq_hit;
          end
        end else if (st == ST_WARM) begin
          st_n = ST_WAKE;
        end else if (st_last) begin
          st_n = (irqw_q && glb_ie && !stack_full) ? ST_TAKE : ST_RUN;
        end
      end
      ST_TAKE: st_n = ST_RUN;
      default: st_n = ST_COLD;
    endcase
  end

  assign st_d   = por ? ST_COLD : st_n;
  assign arm    = (st == ST_RUN) && (st_d == ST_HALT);
  assign st_en  = (st == ST_COLD) || (st == ST_WAKE);
  assign st_clr = por || ((st_d == ST_WAKE) && (st != ST_WAKE));

  always_ff @(posedge clk) begin
    if (por) begin
      st       <= ST_COLD;
      flag_to  <= 1'b0;
      flag_pdf <= 1'b0;
      irqw_q   <= 1'b0;
    end else begin
      st       <= st_n;
      flag_to  <= to_n;
      flag_pdf <= pdf_n;
      irqw_q   <= irqw_n;
    end
  end

  always_ff @(posedge clk) begin
    full_rst <= is_full_rst(st_d);
    warm_rst <= (st_d == ST_WARM);
    run_en   <= (st_d == ST_RUN);
    int_take <= (st_d == ST_TAKE);
    halted   <= is_parked(st_d);
  end
endmodule

// File: rtl/rstwake_ctrl_chk.sv
module rstwake_ctrl_chk (
  input logic clk,
  input logic por,
  input logic rst_pin,
  input logic halt_cmd,
  input logic clr_wdt,
  input logic wdt_ovf,
  input logic flag_to,
  input logic flag_pdf,
  input logic full_rst,
  input logic warm_rst,
  input logic run_en,
  input logic int_take,
  input logic halted
);
  assert_cold_release_R1: assert property (@(posedge clk) disable iff (por)
    $fell(por) |-> (full_rst && !run_en && !flag_to && !flag_pdf));

  assert_pin_run_R2: assert property (@(posedge clk) disable iff (por)
    (run_en && rst_pin) |=> (full_rst && !run_en && $stable(flag_to) && $stable(flag_pdf)));

  assert_pin_halt_R3: assert property (@(posedge clk) disable iff (por)
    (halted && rst_pin) |=> (full_rst && !halted && !flag_to && flag_pdf));

  assert_wdt_run_R4: assert property (@(posedge clk) disable iff (por)
    (run_en && wdt_ovf && !rst_pin) |=> (full_rst && flag_to && $stable(flag_pdf)));

  assert_halt_entry_R5: assert property (@(posedge clk) disable iff (por)
    (run_en && halt_cmd && !rst_pin && !wdt_ovf) |=> (halted && !run_en && flag_pdf && !flag_to));

  assert_clrwdt_R6: assert property (@(posedge clk) disable iff (por)
    (run_en && clr_wdt && !halt_cmd && !rst_pin && !wdt_ovf) |=> (!flag_pdf && $stable(flag_to)));

  assert_warm_flags_R7: assert property (@(posedge clk) disable iff (por)
    warm_rst |-> (flag_to && flag_pdf && halted));

  assert_warm_single_R7: assert property (@(posedge clk) disable iff (por)
    warm_rst |=> !warm_rst);

  assert_take_slot_R10: assert property (@(posedge clk) disable iff (por)
    int_take |=> (run_en && !int_take));

  assert_take_stalled_R10: assert property (@(posedge clk) disable iff (por)
    int_take |-> !run_en);

  assert_halt_run_excl_R11: assert property (@(posedge clk) disable iff (por)
    !(halted && run_en));

  assert_rst_excl_R12: assert property (@(posedge clk) disable iff (por)
    !(full_rst && warm_rst));
endmodule

bind rstwake_ctrl rstwake_ctrl_chk u_chk (
  .clk      (clk),
  .por      (por),
  .rst_pin  (rst_pin),
  .halt_cmd (halt_cmd),
  .clr_wdt  (clr_wdt),
  .wdt_ovf  (wdt_ovf),
  .flag_to  (flag_to),
  .flag_pdf (flag_pdf),
  .full_rst (full_rst),
  .warm_rst (warm_rst),
  .run_en   (run_en),
  .int_take (int_take),
  .halted   (halted)
);

// File: tb/rstwake_ctrl_test.sv
`timescale 1ns/1ps
module rstwake_ctrl_test;
  localparam int SETTLE = 1024;
  localparam int PA_W   = 8;
  localparam int NIRQ   = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por, rst_pin, halt_cmd, clr_wdt, wdt_ovf, glb_ie, stack_full;
  logic [PA_W-1:0] pa_in, pa_wake_mask;
  logic [NIRQ-1:0] irq_req, irq_en;
  logic flag_to, flag_pdf, full_rst, warm_rst, run_en, int_take, halted;

  int vectors = 0;
  int errs    = 0;
  bit done    = 0;

  rstwake_ctrl #(.SETTLE_CYC(SETTLE), .PA_W(PA_W), .NIRQ(NIRQ)) uut (
    .clk(clk), .por(por), .rst_pin(rst_pin), .halt_cmd(halt_cmd),
    .clr_wdt(clr_wdt), .wdt_ovf(wdt_ovf), .pa_in(pa_in),
    .pa_wake_mask(pa_wake_mask), .irq_req(irq_req), .irq_en(irq_en),
    .glb_ie(glb_ie), .stack_full(stack_full), .flag_to(flag_to),
    .flag_pdf(flag_pdf), .full_rst(full_rst), .warm_rst(warm_rst),
    .run_en(run_en), .int_take(int_take), .halted(halted)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts edges until run_en is seen; nt = edge on which int_take was seen
  task automatic wait_run(output int n, output int nt);
    n = 0; nt = 0;
    do begin
      step(1);
      n++;
      if (int_take && nt == 0) nt = n;
    end while (!run_en && n < 3000);
  endtask

  task automatic do_halt();
    halt_cmd = 1'b1; step(1); halt_cmd = 1'b0;
  endtask

  task automatic flags(input string req, input int to_e, input int pdf_e);
    chk(req, "flag_to", flag_to, to_e);
    chk(req, "flag_pdf", flag_pdf, pdf_e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    int n, nt;
    por = 1; rst_pin = 0; halt_cmd = 0; clr_wdt = 0; wdt_ovf = 0;
    pa_in = '1; pa_wake_mask = '0; irq_req = '0; irq_en = '0;
    glb_ie = 0; stack_full = 0;
    step(3);
    // R1 reset state
    chk("R1", "full_rst", full_rst, 1);
    chk("R1", "run_en", run_en, 0);
    flags("R1", 0, 0);
    por = 0;
    wait_run(n, nt);
    chk("R1", "cold wait edges", n, SETTLE);
    chk("R1", "full_rst after wait", full_rst, 0);
    flags("R1", 0, 0);

    // R5, R8, R11 sweep over each port bit
    for (int b = 0; b < PA_W; b++) begin
      pa_wake_mask = PA_W'(1) << b;
      pa_in = ~pa_wake_mask;          // selected bit low while running
      step(1);
      do_halt();
      chk("R5", "halted", halted, 1);
      chk("R5", "run_en", run_en, 0);
      flags("R5", 0, 1);
      pa_in = '1;                     // rising edge on selected bit
      step(2);
      chk("R8", "halted after rise", halted, 1);
      pa_in = pa_wake_mask;           // falls on unselected bits
      step(2);
      chk("R8", "halted after unmasked fall", halted, 1);
      pa_in = '1;
      step(1);
      pa_in = ~pa_wake_mask;          // selected bit falls
      wait_run(n, nt);
      chk("R8", "wake edges", n, SETTLE + 1);
      chk("R11", "halted at run", halted, 0);
      flags("R8", 0, 1);
      pa_in = '1;
      step(1);
    end
    pa_wake_mask = '0;

    // R9, R10 interrupt wakes
    irq_en = 2'b11; glb_ie = 1; stack_full = 0;
    irq_req = 2'b01;
    step(1);
    do_halt();
    step(3);
    chk("R9", "pending at entry no wake", halted, 1);
    irq_en = 2'b01; irq_req = 2'b11;
    step(3);
    chk("R9", "disabled source no wake", halted, 1);
    irq_en = 2'b11;
    wait_run(n, nt);
    chk("R10", "take edge", nt, SETTLE + 1);
    chk("R10", "run edge", n, SETTLE + 2);
    irq_req = '0;
    step(1);

    glb_ie = 0;
    do_halt();
    irq_req = 2'b01;
    wait_run(n, nt);
    chk("R10", "no-ie run edge", n, SETTLE + 1);
    chk("R10", "no-ie take", nt, 0);
    irq_req = '0; glb_ie = 1; stack_full = 1;
    step(1);
    do_halt();
    irq_req = 2'b10;
    wait_run(n, nt);
    chk("R10", "stack-full run edge", n, SETTLE + 1);
    chk("R10", "stack-full take", nt, 0);
    irq_req = '0; stack_full = 0;
    step(1);

    // R6 clear-watchdog
    clr_wdt = 1; step(1); clr_wdt = 0;
    flags("R6", 0, 0);

    // R7 watchdog during halt
    do_halt();
    wdt_ovf = 1; step(1); wdt_ovf = 0;
    chk("R7", "warm_rst", warm_rst, 1);
    chk("R12", "full_rst with warm", full_rst, 0);
    chk("R7", "halted", halted, 1);
    flags("R7", 1, 1);
    wait_run(n, nt);
    chk("R7", "remaining edges", n, SETTLE + 1);
    chk("R7", "warm_rst after", warm_rst, 0);
    clr_wdt = 1; step(1); clr_wdt = 0;
    flags("R6", 1, 0);

    // R3 pin reset during halt
    do_halt();
    rst_pin = 1; step(2);
    chk("R3", "full_rst", full_rst, 1);
    chk("R3", "halted", halted, 0);
    chk("R3", "run_en", run_en, 0);
    flags("R3", 0, 1);
    rst_pin = 0; step(1);
    chk("R3", "run_en after release", run_en, 1);
    clr_wdt = 1; step(1); clr_wdt = 0;

    // R4 watchdog while running
    wdt_ovf = 1; step(1); wdt_ovf = 0;
    chk("R4", "full_rst", full_rst, 1);
    chk("R4", "run_en", run_en, 0);
    flags("R4", 1, 0);
    step(1);
    chk("R4", "run_en next", run_en, 1);
    chk("R4", "full_rst next", full_rst, 0);

    // R2 pin reset while running
    rst_pin = 1; step(3);
    chk("R2", "full_rst", full_rst, 1);
    chk("R2", "run_en", run_en, 0);
    flags("R2", 1, 0);
    rst_pin = 0; step(1);
    chk("R2", "run_en after release", run_en, 1);
    flags("R2", 1, 0);

    // R1 cold reset again clears flags
    por = 1; step(2);
    chk("R1", "full_rst on por", full_rst, 1);
    flags("R1", 0, 0);
    por = 0;
    wait_run(n, nt);
    chk("R1", "second cold wait", n, SETTLE);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule